// File: doc/BRIEF.md
# Dual-Modulus Clock Prescaler

This block divides a fast input clock by one of two neighbouring ratios, P or P+1, and produces one output period per group of input cycles. A single control level picks the ratio: high selects P, low selects P+1. A downstream frequency synthesizer uses the divided output to clock its own counters, and it drives the control level back so that the total division is any integer in the range the two ratios allow. P is a compile-time parameter from 3 to 128.

The control level is sampled only on the input edge that opens a group. That edge is also the one on which the output rises. A change of the control level partway through a group never shortens or lengthens that group. It applies from the next group. Each group begins with a high phase of ceil(L/2) input cycles, where L is the group length, and ends with a low phase of floor(L/2) cycles. The rising edge therefore marks the boundary between groups.

A small state machine sequences the work, with the states IDLE, HIGH and LOW and three named transitions. T_RELEASE goes from IDLE to HIGH on the first edge after reset. T_HALF goes from HIGH to LOW once the high phase is complete. T_WRAP goes from LOW to HIGH after the last cycle of a group, and it latches a new ratio. A cycle counter and a ratio latch support the state machine.

Top module: `dmod_prescaler`

## Requirements
- R1: While rst_n is low, div_out is low.
- R2: When mod_hi is 1 at the edge that opens a group, the next rising edge of div_out comes exactly P input cycles later.
- R3: When mod_hi is 0 at the edge that opens a group, the next rising edge of div_out comes exactly P+1 input cycles later.
- R4: mod_hi is sampled only on the input edge where div_out rises. A change on any other edge leaves the length of the current group unchanged.
- R5: Within a group of length L, div_out is high for the first ceil(L/2) input cycles and low for the remaining floor(L/2), with exactly one rising edge per group.
- R6: div_out stays low until the first rising input edge after rst_n is released, and goes high on that edge.
- R7: Asserting rst_n low in the middle of a group forces div_out low at once, without waiting for a clock edge. After release, division restarts as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-speed input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_hi | input | 1 | Ratio select: 1 divides by P, 0 divides by P+1 |
| div_out | output | 1 | Divided output, rising once per group |

## Verification
The divider runs with the control held high and then held low. These two runs separate the P ratio from the P+1 ratio and confirm the uneven high and low split for an odd P. A run that changes the control on every cycle at random shows that the ratio follows the level present on the group's opening edge and not a level taken on some other cycle. A run that flips the control right after every rising edge shows that a mid-group change never alters the group in progress. A reset asserted during a high phase shows the asynchronous clear and a clean restart on the first edge after release.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } dmp_state_e;

    // number of high cycles in a group of length len
    function automatic int high_len(input int len);
        return (len + 1) / 2;
    endfunction

endpackage

// File: rtl/dmp_mode_latch.sv
module dmp_mode_latch #(
    parameter int P  = 8,
    parameter int CW = 4
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          grp_start,
    input  logic          mod_hi,
    output logic [CW-1:0] grp_last,
    output logic [CW-1:0] hi_last
);
    import dmp_pkg::*;

    localparam logic [CW-1:0] LAST_SHORT = CW'(P - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(P);
    localparam logic [CW-1:0] HI_SHORT   = CW'(high_len(P) - 1);
    localparam logic [CW-1:0] HI_LONG    = CW'(high_len(P + 1) - 1);

    logic short_q;

    // ratio is taken only on the edge that opens a group
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
        end else if (grp_start) begin
            short_q <= mod_hi;
        end
    end

    always_comb begin
        grp_last = short_q ? LAST_SHORT : LAST_LONG;
        hi_last  = short_q ? HI_SHORT   : HI_LONG;
    end

endmodule

// File: rtl/dmp_phase_counter.sv
module dmp_phase_counter #(
    parameter int CW = 4
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dmp_fsm.sv
module dmp_fsm #(
    parameter int CW = 4
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] grp_last,
    input  logic [CW-1:0] hi_last,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          grp_start,
    output logic          div_out
);
    import dmp_pkg::*;

    dmp_state_e state_q;
    dmp_state_e state_nx;

    // state register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state and counter control
    always_comb begin
        state_nx  = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        grp_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // T_RELEASE
                state_nx  = ST_HIGH;
                cnt_clr   = 1'b1;
                grp_start = 1'b1;
            end
            ST_HIGH: begin
                cnt_inc = 1'b1;
                if (cnt == hi_last) begin
                    // T_HALF
                    state_nx = ST_LOW;
                end
            end
            ST_LOW: begin
                if (cnt == grp_last) begin
                    // T_WRAP
                    state_nx  = ST_HIGH;
                    cnt_clr   = 1'b1;
                    grp_start = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // registered output, free of decode glitches
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            div_out <= 1'b0;
        end else begin
            div_out <= (state_nx == ST_HIGH);
        end
    end

endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler #(
    parameter int P = 8
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic mod_hi,
    output logic div_out
);

    localparam int CW = $clog2(P + 2);

    if (P < 3 || P > 128) begin : g_bad_ratio
        $error("dmod_prescaler: P must lie in 3..128");
    end

    logic [CW-1:0] cnt;
    logic [CW-1:0] grp_last;
    logic [CW-1:0] hi_last;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          grp_start;

    dmp_mode_latch #(.P(P), .CW(CW)) u_latch (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .grp_start (grp_start),
        .mod_hi    (mod_hi),
        .grp_last  (grp_last),
        .hi_last   (hi_last)
    );

    dmp_phase_counter #(.CW(CW)) u_cnt (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .cnt    (cnt)
    );

    dmp_fsm #(.CW(CW)) u_fsm (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .grp_last  (grp_last),
        .hi_last   (hi_last),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .grp_start (grp_start),
        .div_out   (div_out)
    );

endmodule

// File: rtl/dmod_prescaler_chk.sv
module dmod_prescaler_chk #(
    parameter int P = 8
) (
    input logic clk_in,
    input logic rst_n,
    input logic mod_hi,
    input logic div_out
);

    localparam int GW = $clog2(P + 3);

    logic          prev_out;
    logic          mod_prev;
    logic          mode_grp;
    logic          seen_rise;
    logic [GW-1:0] gap;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            prev_out  <= 1'b0;
            mod_prev  <= 1'b0;
            mode_grp  <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            prev_out <= div_out;
            mod_prev <= mod_hi;
            if (div_out && !prev_out) begin
                gap       <= GW'(1);
                mode_grp  <= mod_prev;
                seen_rise <= 1'b1;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R2 R3 R4
    group_len_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (div_out && !prev_out && seen_rise) |->
            (gap == (mode_grp ? GW'(P) : GW'(P + 1))));

    // R5
    high_len_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!div_out && prev_out && seen_rise) |->
            (gap == (mode_grp ? GW'((P + 1) / 2) : GW'((P + 2) / 2))));

    // R5
    rise_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(div_out) |=> div_out);

    // R6
    first_rise_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(rst_n) |=> div_out);

endmodule

bind dmod_prescaler dmod_prescaler_chk #(.P(P)) u_chk (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .mod_hi  (mod_hi),
    .div_out (div_out)
);

// File: tb/tb_dmod_prescaler.sv
`timescale 1ns/1ps
module tb_dmod_prescaler;

    localparam int P = 5;

    logic clk_in = 1'b0;
    logic rst_n  = 1'b0;
    logic mod_hi = 1'b1;
    logic div_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  r4_phase = 1'b0;

    always #2.5 clk_in = ~clk_in;

    dmod_prescaler #(.P(P)) dut (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .mod_hi  (mod_hi),
        .div_out (div_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard: expected group lengths, pushed when a group opens
    int  exp_q[$];
    bit  prev_s    = 1'b0;
    bit  mod_seen  = 1'b0;
    bit  have_grp  = 1'b0;
    bit  grp_mode  = 1'b0;
    int  cyc_cnt   = 0;
    int  hi_cnt    = 0;

    always @(negedge clk_in) begin
        if (!rst_n) begin
            check(div_out == 1'b0, "R1", "output during reset", int'(div_out), 0);
            exp_q.delete();
            prev_s   = 1'b0;
            have_grp = 1'b0;
        end else begin
            if (div_out && !prev_s) begin
                if (have_grp) begin
                    int exp_len;
                    string tag;
                    exp_len = exp_q.pop_front();
                    tag = r4_phase ? "R4" : (grp_mode ? "R2" : "R3");
                    check(cyc_cnt == exp_len, tag, "group length", cyc_cnt, exp_len);
                    check(hi_cnt == (exp_len + 1) / 2, "R5", "high cycles",
                          hi_cnt, (exp_len + 1) / 2);
                end
                grp_mode = mod_seen;
                exp_q.push_back(mod_seen ? P : P + 1);
                have_grp = 1'b1;
                cyc_cnt  = 1;
                hi_cnt   = 1;
            end else begin
                cyc_cnt++;
                if (div_out) hi_cnt++;
            end
            prev_s = div_out;
        end
        mod_seen = mod_hi;
    end

    task automatic release_and_check_start();
        @(posedge clk_in); #1;
        rst_n = 1'b1;
        @(negedge clk_in); #0.5;
        check(div_out == 1'b0, "R6", "low before first edge", int'(div_out), 0);
        @(negedge clk_in); #0.5;
        check(div_out == 1'b1, "R6", "high after first edge", int'(div_out), 1);
    endtask

    task automatic wait_rise();
        bit last;
        last = div_out;
        forever begin
            @(negedge clk_in); #0.5;
            if (div_out && !last) break;
            last = div_out;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk_in);
        release_and_check_start();

        // R2: ratio held at P
        mod_hi = 1'b1;
        repeat (8) wait_rise();

        // R3: ratio held at P+1
        @(posedge clk_in); #1 mod_hi = 1'b0;
        repeat (8) wait_rise();

        // random level on every cycle
        for (int i = 0; i < 400; i++) begin
            @(posedge clk_in); #1 mod_hi = 1'($urandom);
        end

        // R4: flip the level right after each group opens
        wait_rise();
        r4_phase = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk_in); #1 mod_hi = ~mod_hi;
            wait_rise();
        end
        wait_rise();
        r4_phase = 1'b0;

        // R7: asynchronous reset during a high phase
        mod_hi = 1'b1;
        wait_rise();
        #1 rst_n = 1'b0;
        #0.5;
        check(div_out == 1'b0, "R7", "async clear", int'(div_out), 0);
        repeat (3) @(posedge clk_in);
        release_and_check_start();
        repeat (4) wait_rise();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule